// File: doc/BRIEF.md
# Keyed Soft Reset Register

This block sits on the register slave port of a peripheral and lets software put the whole peripheral back into its default state. It has no storage that software can see. A write to its address whose low nibble carries the unlock key starts an internal reset pulse of fixed length. Any other value written to that address, and any read of it, is refused with a bus error.

The bus write that carries the key is not acknowledged when it arrives. The acknowledge is held back until the reset pulse has ended. A master that waits for the response therefore cannot issue another access to the peripheral while its registers are being cleared.

The port uses a request/response handshake. The master raises `bus_req` with the address, the direction and the data, and holds them until it sees a one-cycle `bus_ack` or `bus_err`. It then drops `bus_req`. Requests to other addresses are left to the rest of the peripheral and get no response from this block. The `soft_rst` output is active high and comes straight from a flip-flop. It drives the reset of every other register in the peripheral, including the serial bus busy flag.

Top module: `keyed_reset_reg`

## Requirements
- R1: A write to address `REG_ADDR` (default 0x40) whose bits [3:0] equal the key `KEY` (default 4'hA) is accepted when the block is idle. One cycle after it is accepted, `soft_rst` goes high and stays high for exactly `PULSE_LEN` cycles (default 4). Bits [31:4] of the data have no effect on this.
- R2: A key write gets a `bus_ack` in the same cycle that `soft_rst` falls, which is `PULSE_LEN`+1 cycles after the accepting edge. No `bus_ack` is given while `soft_rst` is high.
- R3: A write to `REG_ADDR` whose bits [3:0] differ from `KEY` gets `bus_err` one cycle after the accepting edge. It produces no reset pulse.
- R4: A read of `REG_ADDR` gets `bus_err` one cycle after the accepting edge. It produces no reset pulse, and `bus_rdata` is always zero.
- R5: A request to any other address gets neither `bus_ack` nor `bus_err` and produces no reset pulse.
- R6: `bus_ack` and `bus_err` are one-cycle pulses. They are never high together, and a request gets exactly one response.
- R7: A request that is still held, or that changes, while a pulse is running is not looked at. After any response there is one dead cycle. A request still held after the response is therefore accepted again two cycles after the response edge.
- R8: The synchronous hardware reset `rst` drives `soft_rst`, `bus_ack` and `bus_err` low on the next edge. It clears the pulse counter and abandons a key write in progress without acknowledging it. The next key write produces a full-length pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_req | input | 1 | Request, held until a response is seen |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address of the request |
| bus_wdata | input | DATA_W | Write data; only bits [KEY_W-1:0] are compared |
| bus_rdata | output | DATA_W | Read data, always zero |
| bus_ack | output | 1 | One-cycle successful completion |
| bus_err | output | 1 | One-cycle error completion |
| soft_rst | output | 1 | Registered reset pulse to the rest of the peripheral |

## Verification
The bench checks that the pulse is exactly four cycles long and that the acknowledge lands on the cycle the pulse drops. A design that acknowledged at once, or one cycle late, would show up as a wrong latency, and a counter off by one would show up as a wrong pulse count. It also checks that only the low nibble is compared: a key placed in bits [7:4] must be refused, and a key with all the upper bits set must be accepted. These catch a full-word compare or a compare on the wrong nibble.

The bench holds a request through a pulse and changes its data part way through. A design that re-sampled the request during the pulse, or took it again in the response cycle, would give an early error or a second response. A hardware reset in the middle of a pulse must cut the pulse short and drop the pending acknowledge, and the next key write must still get a full pulse.

// File: rtl/kr_pkg.sv
package kr_pkg;

  // Classification of the request presented on the port in the current cycle
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,   // no request, or not our address
    ACC_KEY  = 2'd1,   // write with the correct key nibble
    ACC_BAD  = 2'd2,   // write with any other nibble
    ACC_READ = 2'd3    // read of the write-only register
  } acc_e;

  // Control sequence of the register
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_RESP  = 2'd2
  } st_e;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/kr_decode.sv
module kr_decode
  import kr_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          KEY_W    = 4,
  parameter logic [7:0]  REG_ADDR = 8'h40,
  parameter logic [3:0]  KEY      = 4'hA
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [KEY_W-1:0]  key_nib,
  output acc_e              kind
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);
  localparam logic [KEY_W-1:0]  MY_KEY  = KEY_W'(KEY);

  logic hit;
  assign hit = req && (addr == MY_ADDR);

  always_comb begin
    kind = ACC_NONE;
    if (hit) begin
      if (!we)                  kind = ACC_READ;
      else if (key_nib == MY_KEY) kind = ACC_KEY;
      else                      kind = ACC_BAD;
    end
  end

endmodule

// File: rtl/kr_pulse_timer.sv
module kr_pulse_timer
  import kr_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pulse,
  output logic last
);

  localparam int             CNT_W = cnt_width(PULSE_LEN);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0] cnt;

  // Pulse is in its final cycle when the counter has run down
  assign last = pulse && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      cnt   <= '0;
    end else if (start && !pulse) begin
      pulse <= 1'b1;
      cnt   <= LOAD;
    end else if (pulse) begin
      if (cnt == '0) pulse <= 1'b0;
      else           cnt   <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/kr_respond.sv
module kr_respond (
  input  logic clk,
  input  logic rst,
  input  logic fire_ack,
  input  logic fire_err,
  output logic ack,
  output logic err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0;
      err <= 1'b0;
    end else begin
      ack <= fire_ack;
      err <= fire_err && !fire_ack;
    end
  end

endmodule

// File: rtl/keyed_reset_reg.sv
module keyed_reset_reg
  import kr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter int          KEY_W     = 4,
  parameter logic [7:0]  REG_ADDR  = 8'h40,
  parameter logic [3:0]  KEY       = 4'hA,
  parameter int          PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic              soft_rst
);

  acc_e kind;
  st_e  state, nxt;
  logic start, last, fire_ack, fire_err;

  // Bits above the key nibble take no part in the decision
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:KEY_W];

  assign bus_rdata = '0;

  kr_decode #(
    .ADDR_W(ADDR_W), .KEY_W(KEY_W), .REG_ADDR(REG_ADDR), .KEY(KEY)
  ) i_decode (
    .req(bus_req), .we(bus_we), .addr(bus_addr),
    .key_nib(bus_wdata[KEY_W-1:0]), .kind(kind)
  );

  kr_pulse_timer #(.PULSE_LEN(PULSE_LEN)) i_timer (
    .clk(clk), .rst(rst), .start(start), .pulse(soft_rst), .last(last)
  );

  kr_respond i_resp (
    .clk(clk), .rst(rst), .fire_ack(fire_ack), .fire_err(fire_err),
    .ack(bus_ack), .err(bus_err)
  );

  always_comb begin
    nxt      = state;
    start    = 1'b0;
    fire_ack = 1'b0;
    fire_err = 1'b0;
    unique case (state)
      ST_IDLE: begin
        unique case (kind)
          ACC_KEY:  begin start = 1'b1;    nxt = ST_PULSE; end
          ACC_BAD,
          ACC_READ: begin fire_err = 1'b1; nxt = ST_RESP;  end
          default:  ;
        endcase
      end
      ST_PULSE: begin
        // Request lines are not examined here: the access is stalled
        if (last) begin
          fire_ack = 1'b1;
          nxt      = ST_RESP;
        end
      end
      ST_RESP:  nxt = ST_IDLE;   // dead cycle lets the master drop its request
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

endmodule

// File: rtl/kr_checker.sv
module kr_checker #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter int          KEY_W     = 4,
  parameter logic [7:0]  REG_ADDR  = 8'h40,
  parameter logic [3:0]  KEY       = 4'hA,
  parameter int          PULSE_LEN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [KEY_W-1:0]  key_nib,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              soft_rst
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);
  localparam logic [KEY_W-1:0]  MY_KEY  = KEY_W'(KEY);

  logic [15:0] high_cnt;
  always_ff @(posedge clk) begin
    if (rst)           high_cnt <= '0;
    else if (soft_rst) high_cnt <= high_cnt + 16'd1;
    else               high_cnt <= '0;
  end

  assert_rst_clears_R8: assert property (@(posedge clk)
    rst |=> (!soft_rst && !bus_ack && !bus_err));

  assert_pulse_len_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(soft_rst) && !$past(rst)) |-> (high_cnt == 16'(PULSE_LEN)));

  assert_rise_cause_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(soft_rst) |-> $past(bus_req && bus_we && bus_addr == MY_ADDR && key_nib == MY_KEY));

  assert_ack_at_end_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(soft_rst) && !$past(rst)) |-> bus_ack);

  assert_no_ack_in_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> !bus_ack);

  assert_err_cause_R3: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_req && bus_addr == MY_ADDR && !(bus_we && key_nib == MY_KEY)));

  assert_rdata_zero_R4: assert property (@(posedge clk) disable iff (rst)
    bus_rdata == '0);

  assert_one_resp_R6: assert property (@(posedge clk) disable iff (rst)
    !(bus_ack && bus_err));

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_ack || bus_err) |=> !(bus_ack || bus_err));

endmodule

bind keyed_reset_reg kr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
  .REG_ADDR(REG_ADDR), .KEY(KEY), .PULSE_LEN(PULSE_LEN)
) i_checker (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .key_nib(bus_wdata[KEY_W-1:0]),
  .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
  .soft_rst(soft_rst)
);

// File: tb/test_keyed_reset_reg.sv
`timescale 1ns/1ps
module test_keyed_reset_reg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_req = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_ack, bus_err, soft_rst;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  keyed_reset_reg i_keyed_reset_reg (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .soft_rst(soft_rst)
  );

  // kind: 0 key write, 1 refused write, 2 read, 3 other address
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 8'h40, 32'h0000000A, 2'd0},
    {1'b1, 8'h40, 32'h00000005, 2'd1},
    {1'b1, 8'h40, 32'hFFFFFFFA, 2'd0},
    {1'b1, 8'h40, 32'h000000A0, 2'd1},
    {1'b0, 8'h40, 32'h0000000A, 2'd2},
    {1'b1, 8'h44, 32'h0000000A, 2'd3},
    {1'b1, 8'h40, 32'h12345670, 2'd1},
    {1'b1, 8'h40, 32'h8765432A, 2'd0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One access: returns latency (0 = none), pulse cycles, response kind,
  // read data at response and whether the cycle after is quiet
  task automatic access(input logic we, input logic [7:0] addr, input logic [31:0] data,
                        output int lat, output int pulses, output bit got_ack,
                        output bit got_err, output logic [31:0] rd, output bit quiet);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = data;
    lat = 0; pulses = 0; got_ack = 0; got_err = 0; rd = '0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (soft_rst) pulses++;
      if (bus_ack || bus_err) begin
        lat = k; got_ack = bus_ack; got_err = bus_err; rd = bus_rdata;
        break;
      end
    end
    bus_req = 1'b0;
    @(negedge clk);
    quiet = !bus_ack && !bus_err && !soft_rst;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat, pulses, cnt_err, cnt_ack, first_err;
    bit ga, ge, quiet;
    logic [31:0] rd;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(!soft_rst && !bus_ack && !bus_err, "R8 reset state", soft_rst, 0);

    for (int i = 0; i < NV; i++) begin
      logic        we;
      logic [7:0]  ad;
      logic [31:0] dt;
      logic [1:0]  kd;
      {we, ad, dt, kd} = VEC[i];
      access(we, ad, dt, lat, pulses, ga, ge, rd, quiet);
      case (kd)
        2'd0: begin
          check(pulses == 4, "R1 pulse length", pulses, 4);
          check(ga && lat == 5, "R2 ack latency", lat, 5);
          check(quiet, "R6 single ack", quiet, 1);
        end
        2'd1: begin
          check(ge && lat == 1, "R3 refused write err latency", lat, 1);
          check(pulses == 0, "R3 no pulse", pulses, 0);
          check(quiet, "R6 single err", quiet, 1);
        end
        2'd2: begin
          check(ge && lat == 1, "R4 read err latency", lat, 1);
          check(pulses == 0 && rd == 0, "R4 no pulse zero data", pulses + int'(rd != 0), 0);
        end
        default: begin
          check(lat == 0 && pulses == 0 && quiet, "R5 other address ignored", lat + pulses, 0);
        end
      endcase
    end

    // R7: request held through a pulse, data turned bad part way
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h40; bus_wdata = 32'hA;
    cnt_err = 0; cnt_ack = 0; first_err = 0; pulses = 0; lat = 0;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      if (soft_rst) pulses++;
      if (k == 2) bus_wdata = 32'h5;
      if (bus_ack) begin cnt_ack++; lat = k; end
      if (bus_err) begin cnt_err++; if (first_err == 0) first_err = k; bus_req = 1'b0; end
    end
    check(pulses == 4 && lat == 5, "R7 pulse unaffected by held request", lat, 5);
    check(cnt_ack == 1, "R7 one ack", cnt_ack, 1);
    check(cnt_err == 1 && first_err == 7, "R7 re-accepted after dead cycle", first_err, 7);

    // R8: hardware reset during a pulse
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h40; bus_wdata = 32'hA;
    repeat (2) @(negedge clk);
    check(soft_rst, "R8 pulse running before reset", soft_rst, 1);
    rst = 1'b1; bus_req = 1'b0;
    @(negedge clk);
    check(!soft_rst, "R8 reset cuts pulse", soft_rst, 0);
    @(negedge clk);
    rst = 1'b0;
    cnt_ack = 0; pulses = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (bus_ack || bus_err) cnt_ack++;
      if (soft_rst) pulses++;
    end
    check(cnt_ack == 0 && pulses == 0, "R8 abandoned write gets no response", cnt_ack + pulses, 0);
    access(1'b1, 8'h40, 32'h0000000A, lat, pulses, ga, ge, rd, quiet);
    check(pulses == 4 && ga && lat == 5, "R8 full pulse after reset", pulses, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule